// File: doc/BRIEF.md
# Bidirectional GPIO port bank

This block gives a small 8-bit processor bus two general-purpose I/O ports: a wide port of eight pins and a narrow port of four pins. Each port owns a data latch and a direction register, both reached through an address, a write strobe, write data and a registered read-data word. Every pin leaves the block as a tri-state triple: an output level, an output enable and an input level coming back from the pad.

A direction bit of 1 turns its pin into an output, driven from the data latch. A direction bit of 0 leaves the pin as an input, sampled through a two-flop synchronizer. A read of a data register is assembled bit by bit. Output bits return what was last written to the latch. Input bits return the synchronized pad level. Reset puts every pin back to input. The data latches are not cleared, so software can load output values before it switches any pin to output.

Top module: `gpio_bank`

## Requirements
- R1: The wide port's data register is at address 0x01 and its direction register at 0x05. The narrow port's data register is at 0x02 and its direction register at 0x06. bus_rdata shows, one clock later, the register addressed in the previous cycle. A write is taken on the clock edge where bus_wr is 1.
- R2: For each pin, the output enable equals the pin's direction bit. The output level equals the data latch bit while that direction bit is 1, and is 0 while it is 0.
- R3: While rst is high at a clock edge, every direction bit clears to 0 and bus_rdata clears to 0x00, so all pins come out of reset as inputs.
- R4: Reset leaves both data latches unchanged; after reset they still hold the last values written.
- R5: Reading a data register returns the data latch value for every bit whose direction bit is 1, even when the pad shows a different level.
- R6: Reading a data register returns the pad level for every bit whose direction bit is 0, through two synchronizing flops. A pad change set up before clock edge k shows in bus_rdata after edge k+2, with the data address held.
- R7: Both direction registers can be written and read back unchanged (narrow port: low four bits).
- R8: A data write updates the latch for all bits, including bits set as inputs. A bit switched to output later drives the last value written to it.
- R9: On the narrow port, bits 7:4 of both registers read as 0, and writing them has no effect.
- R10: A read from any address other than the four mapped ones returns 0x00, and a write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the previous cycle's address |
| wide_pin_in | input | 8 | Pad levels of the wide port |
| wide_pin_out | output | 8 | Output levels of the wide port |
| wide_pin_oe | output | 8 | Output enables of the wide port |
| narrow_pin_in | input | 4 | Pad levels of the narrow port |
| narrow_pin_out | output | 4 | Output levels of the narrow port |
| narrow_pin_oe | output | 4 | Output enables of the narrow port |

## Verification
The hardest case to reach from the ports is a latch value that must survive a reset. The bench first loads both latches while every pin is still an input, pulses reset, then switches all pins to output. The latch contents only become visible again at that point, and they must match the pre-reset values.

Random rounds also drive pads that differ from the latches and then flip direction bits. This checks that each readback bit takes its source from its own direction bit. A directed run holds the data address steady and counts the edges until a pad change reaches the read word.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int BUS_W  = 8;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] WIDE_DATA_ADDR   = 8'h01;
  localparam logic [ADDR_W-1:0] NARROW_DATA_ADDR = 8'h02;
  localparam logic [ADDR_W-1:0] WIDE_DIR_ADDR    = 8'h05;
  localparam logic [ADDR_W-1:0] NARROW_DIR_ADDR  = 8'h06;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2
  } port_sel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_bank_pkg::*;
#(
  parameter int                WIDTH     = 8,
  parameter int                SYNC_LEN  = 2,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h01,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 8'h05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic [BUS_W-1:0]  rd_word
);

  port_sel_e        sel;
  logic [WIDTH-1:0] wr_bits;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] pin_sync;
  logic [BUS_W-1:0] data_view;
  logic [BUS_W-1:0] dir_view;

  always_comb begin
    if (bus_addr == DATA_ADDR)     sel = SEL_DATA;
    else if (bus_addr == DIR_ADDR) sel = SEL_DIR;
    else                           sel = SEL_NONE;
  end

  assign wr_bits = WIDTH'(bus_wdata);

  // data latch: deliberately outside reset
  always_ff @(posedge clk) begin
    if (bus_wr && sel == SEL_DATA) latch_q <= wr_bits;
  end

  always_ff @(posedge clk) begin
    if (rst)                           dir_q <= '0;
    else if (bus_wr && sel == SEL_DIR) dir_q <= wr_bits;
  end

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_LEN)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  generate
    for (genvar b = 0; b < BUS_W; b++) begin : g_view
      if (b < WIDTH) begin : g_live
        assign data_view[b] = dir_q[b] ? latch_q[b] : pin_sync[b];
        assign dir_view[b]  = dir_q[b];
      end else begin : g_pad
        assign data_view[b] = 1'b0;
        assign dir_view[b]  = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    case (sel)
      SEL_DATA: rd_word = data_view;
      SEL_DIR:  rd_word = dir_view;
      default:  rd_word = '0;
    endcase
  end

  assign pin_oe  = dir_q;
  assign pin_out = latch_q & dir_q;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int WIDE_W   = 8,
  parameter int NARROW_W = 4,
  parameter int SYNC_LEN = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic [WIDE_W-1:0]   wide_pin_in,
  output logic [WIDE_W-1:0]   wide_pin_out,
  output logic [WIDE_W-1:0]   wide_pin_oe,
  input  logic [NARROW_W-1:0] narrow_pin_in,
  output logic [NARROW_W-1:0] narrow_pin_out,
  output logic [NARROW_W-1:0] narrow_pin_oe
);

  logic [BUS_W-1:0] wide_rd;
  logic [BUS_W-1:0] narrow_rd;

  gpio_port_regs #(
    .WIDTH(WIDE_W), .SYNC_LEN(SYNC_LEN),
    .DATA_ADDR(WIDE_DATA_ADDR), .DIR_ADDR(WIDE_DIR_ADDR)
  ) u_wide (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .pin_in(wide_pin_in), .pin_out(wide_pin_out),
    .pin_oe(wide_pin_oe), .rd_word(wide_rd)
  );

  gpio_port_regs #(
    .WIDTH(NARROW_W), .SYNC_LEN(SYNC_LEN),
    .DATA_ADDR(NARROW_DATA_ADDR), .DIR_ADDR(NARROW_DIR_ADDR)
  ) u_narrow (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .pin_in(narrow_pin_in), .pin_out(narrow_pin_out),
    .pin_oe(narrow_pin_oe), .rd_word(narrow_rd)
  );

  // address windows are disjoint, so an OR merges the two read words
  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= wide_rd | narrow_rd;
  end

endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker
  import gpio_bank_pkg::*;
#(
  parameter int WIDE_W   = 8,
  parameter int NARROW_W = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic [BUS_W-1:0]    bus_wdata,
  input logic [BUS_W-1:0]    bus_rdata,
  input logic [WIDE_W-1:0]   wide_pin_out,
  input logic [WIDE_W-1:0]   wide_pin_oe,
  input logic [NARROW_W-1:0] narrow_pin_out,
  input logic [NARROW_W-1:0] narrow_pin_oe
);

  logic mapped;
  assign mapped = (bus_addr == WIDE_DATA_ADDR) || (bus_addr == WIDE_DIR_ADDR) ||
                  (bus_addr == NARROW_DATA_ADDR) || (bus_addr == NARROW_DIR_ADDR);

  assert_dir_write_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == WIDE_DIR_ADDR) |=> wide_pin_oe == $past(bus_wdata[WIDE_W-1:0]));

  assert_reset_inputs_R3: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wide_pin_oe == '0 && narrow_pin_oe == '0 && bus_rdata == '0));

  assert_out_gated_R2: assert property (@(posedge clk) disable iff (rst)
    ((wide_pin_out & ~wide_pin_oe) == '0) && ((narrow_pin_out & ~narrow_pin_oe) == '0));

  assert_latch_write_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == WIDE_DATA_ADDR) |=>
      (wide_pin_out & wide_pin_oe) == ($past(bus_wdata[WIDE_W-1:0]) & wide_pin_oe));

  assert_narrow_upper_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == NARROW_DATA_ADDR || bus_addr == NARROW_DIR_ADDR) |=>
      bus_rdata[BUS_W-1:NARROW_W] == '0);

  assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> bus_rdata == '0);

  assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !mapped) |=> ($stable(wide_pin_oe) && $stable(narrow_pin_oe) &&
                             $stable(wide_pin_out) && $stable(narrow_pin_out)));

endmodule

bind gpio_bank gpio_bank_checker #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .wide_pin_out(wide_pin_out), .wide_pin_oe(wide_pin_oe),
  .narrow_pin_out(narrow_pin_out), .narrow_pin_oe(narrow_pin_oe)
);

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] wide_pin_in = 8'h00;
  logic [7:0] wide_pin_out, wide_pin_oe;
  logic [3:0] narrow_pin_in = 4'h0;
  logic [3:0] narrow_pin_out, narrow_pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0] m_wl = 8'h00, m_wd = 8'h00;
  logic [3:0] m_nl = 4'h0,  m_nd = 4'h0;

  always #5 clk = ~clk;

  gpio_bank uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wide_pin_in(wide_pin_in), .wide_pin_out(wide_pin_out), .wide_pin_oe(wide_pin_oe),
    .narrow_pin_in(narrow_pin_in), .narrow_pin_out(narrow_pin_out),
    .narrow_pin_oe(narrow_pin_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    case (a)
      8'h01:   return (m_wd & m_wl) | (~m_wd & wide_pin_in);
      8'h05:   return m_wd;
      8'h02:   return {4'h0, (m_nd & m_nl) | (~m_nd & narrow_pin_in)};
      8'h06:   return {4'h0, m_nd};
      default: return 8'h00;
    endcase
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'h00;
    case (a)
      8'h01: m_wl = d;
      8'h05: m_wd = d;
      8'h02: m_nl = d[3:0];
      8'h06: m_nd = d[3:0];
      default: ;
    endcase
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_addr = 8'h00;
  endtask

  task automatic read_check(input string tag, input logic [7:0] a);
    logic [7:0] d;
    bus_read(a, d);
    check(tag, d, exp_read(a));
  endtask

  task automatic pin_check(input string tag);
    check({tag, " wide oe"},   wide_pin_oe, m_wd);
    check({tag, " wide out"},  wide_pin_out, m_wl & m_wd);
    check({tag, " narrow oe"}, {4'h0, narrow_pin_oe}, {4'h0, m_nd});
    check({tag, " narrow out"}, {4'h0, narrow_pin_out}, {4'h0, m_nl & m_nd});
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R3: reset state
    check("R3 rdata after reset", bus_rdata, 8'h00);
    check("R3 wide oe after reset", wide_pin_oe, 8'h00);
    check("R3 narrow oe after reset", {4'h0, narrow_pin_oe}, 8'h00);
    read_check("R3 wide dir reads 0", 8'h05);

    // R8: latch loads while pins are inputs
    wide_pin_in = 8'h0F; narrow_pin_in = 4'h3;
    bus_write(8'h01, 8'hA5);
    bus_write(8'h02, 8'hF9);
    pin_check("R8 latch hidden while input");
    settle();
    read_check("R6 wide input bits read pad", 8'h01);

    // R4: latches survive reset
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    m_wd = 8'h00; m_nd = 4'h0;
    pin_check("R3 pins inputs after reset");
    bus_write(8'h05, 8'hFF);
    bus_write(8'h06, 8'h0F);
    read_check("R4 wide latch kept through reset", 8'h01);
    read_check("R4 narrow latch kept through reset", 8'h02);
    pin_check("R2 all outputs");

    // R5: output bits ignore pad
    wide_pin_in = 8'h5A; narrow_pin_in = 4'h6;
    settle();
    read_check("R5 wide latch not pad", 8'h01);
    read_check("R5 narrow latch not pad", 8'h02);

    // R9: narrow upper bits
    bus_write(8'h06, 8'hF5);
    read_check("R9 narrow dir upper zero", 8'h06);
    bus_write(8'h02, 8'hEC);
    read_check("R9 narrow data upper zero", 8'h02);

    // R10: unmapped
    bus_write(8'h03, 8'hFF);
    bus_write(8'h00, 8'h00);
    bus_write(8'h07, 8'h33);
    read_check("R10 unmapped write left wide dir", 8'h05);
    read_check("R10 unmapped write left wide data", 8'h01);
    read_check("R10 unmapped write left narrow dir", 8'h06);
    read_check("R10 unmapped read 0x04", 8'h04);
    read_check("R10 unmapped read 0xFF", 8'hFF);

    // R6: synchronizer latency with the data address held
    bus_write(8'h05, 8'h00);
    wide_pin_in = 8'h00;
    @(negedge clk); bus_addr = 8'h01;
    settle();
    wide_pin_in = 8'h3C;
    @(negedge clk); check("R6 latency edge 1", bus_rdata, 8'h00);
    @(negedge clk); check("R6 latency edge 2", bus_rdata, 8'h00);
    @(negedge clk); check("R6 latency edge 3", bus_rdata, 8'h3C);
    bus_addr = 8'h00;

    // R1: one-cycle registered read
    bus_write(8'h05, 8'h96);
    @(negedge clk); bus_addr = 8'h05;
    @(negedge clk); bus_addr = 8'h00; d = bus_rdata;
    check("R1 read follows prior address", d, 8'h96);
    @(negedge clk); check("R1 read returns to zero", bus_rdata, 8'h00);

    // random rounds
    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: bus_write(8'h01, 8'($urandom));
        1: bus_write(8'h05, 8'($urandom));
        2: bus_write(8'h02, 8'($urandom));
        3: bus_write(8'h06, 8'($urandom));
        4: bus_write(8'($urandom_range(7, 255)), 8'($urandom));
        default: begin
          @(negedge clk);
          wide_pin_in = 8'($urandom); narrow_pin_in = 4'($urandom);
        end
      endcase
      settle();
      pin_check("R2 random");
      read_check("R5 R6 random wide data", 8'h01);
      read_check("R7 random wide dir", 8'h05);
      read_check("R5 R6 random narrow data", 8'h02);
      read_check("R7 R9 random narrow dir", 8'h06);
      if (i % 10 == 0) read_check("R10 random unmapped", 8'($urandom_range(7, 255)));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule